// File: doc/BRIEF.md
# Luma Peaking Filter with Coring

This block sharpens a stream of 8-bit luma samples. It boosts the middle and upper parts of the luma band. A detail signal is taken from a symmetric five-tap neighbourhood of the current sample. Two programmable power-of-two weights shape it. The near neighbours (n±1) carry a high-pass term that peaks at half the sample rate. The far neighbours (n±2) carry a band-pass term centred at a quarter of the sample rate. Together they give the impulse response [−α, −β, 1+2α+2β, −β, −α].

Before the detail is added back to the sample, a coring stage removes detail of very small magnitude and treats it as noise. A limiter then clips the widened sum to a 9-bit unsigned result. That result carries one fractional bit, so a sample that is not sharpened leaves the block as twice its input code.

Samples arrive one per clock with a valid strobe. A line is a contiguous run of valid samples. At the ends of a line, the missing neighbours are replaced by repeating the edge sample. The output stream keeps the input order. It has a fixed latency and one output per input.

Top module: `luma_peaker`

## Requirements
- R1: When both weight codes are 00, every output equals the input sample shifted left by one bit (output = 2·x), whatever the coring code.
- R2: Weight codes are 2 bits: 00 = 0, 01 = 1/8, 10 = 1/4, 11 = 1/2. `cfg_bp_wt` (α) weights the taps at n±2 and `cfg_hp_wt` (β) weights the taps at n±1.
- R3: With D = α·(2x[n]−x[n−2]−x[n+2]) + β·(2x[n]−x[n−1]−x[n+1]) in input-LSB units, the output before limiting is floor(2·(x[n] + D)). All fractional parts of D are kept until this single truncation.
- R4: Coring codes are 2 bits: 00 = off, 01 = 1/2, 10 = 3/4, 11 = 7/8 of one 10-bit LSB (one 10-bit LSB is 1/4 of an input LSB). A detail value whose magnitude is at or below the threshold is replaced by zero, and equality is cored.
- R5: A detail value whose magnitude is above the threshold is added unchanged.
- R6: The result is clipped to 0 when negative and to 511 when above 511.
- R7: Each accepted input sample yields exactly one output with `out_valid` high. That output appears after the fifth rising edge following the edge that accepts the sample.
- R8: `out_luma` is zero in every cycle in which `out_valid` is low.
- R9: Lines are runs of consecutive `in_valid` cycles, separated by at least one idle cycle. A neighbour outside the current line is replaced by the nearest sample of the same line, so a one-sample line outputs 2·x.
- R10: While `rst_n` is low, `out_valid` and `out_luma` are zero. Samples in flight at reset never appear at the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_luma | input | 8 | Unsigned luma sample |
| cfg_bp_wt | input | 2 | Band-pass weight code (α) |
| cfg_hp_wt | input | 2 | High-pass weight code (β) |
| cfg_core | input | 2 | Coring threshold code |
| out_valid | output | 1 | Output sample strobe |
| out_luma | output | 9 | Peaked luma, one fractional bit |

## Verification
The assertions assume that the three configuration fields change only while no sample is in flight, because the pass-through check reads the weights three cycles before the result it guards. They also assume that lines are separated by at least one idle cycle, since nothing marks a line boundary other than a gap in `in_valid`. The stimulus therefore sets the configuration, waits for the pipeline to drain, and only then drives a line. Every line is followed by one or more idle cycles. The back-to-back case uses exactly one idle cycle, to exercise the tightest boundary the block accepts.

// File: rtl/luma_pk_pkg.sv
package luma_pk_pkg;

    // cycles from the accepting edge to the edge that updates the output
    localparam int LATENCY = 5;
    // fine detail unit is 1/32 of an input LSB
    localparam int FINE_SH = 5;
    // fine units to half-LSB output units
    localparam int OUT_SH  = 4;

    typedef enum logic [1:0] {
        WT_ZERO    = 2'b00,
        WT_EIGHTH  = 2'b01,
        WT_QUARTER = 2'b10,
        WT_HALF    = 2'b11
    } wt_e;

    typedef enum logic [1:0] {
        CORE_OFF   = 2'b00,
        CORE_HALF  = 2'b01,
        CORE_3Q    = 2'b10,
        CORE_7E    = 2'b11
    } core_e;

    // coring threshold in fine units (8 fine units per 10-bit LSB)
    function automatic int unsigned core_limit(input logic [1:0] code);
        case (code)
            CORE_HALF: return 4;
            CORE_3Q:   return 6;
            CORE_7E:   return 7;
            default:   return 0;
        endcase
    endfunction

endpackage

// File: rtl/luma_pk_window.sv
module luma_pk_window #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_pix,
    output logic             ctr_valid,
    output logic [PIX_W-1:0] tap_m2,
    output logic [PIX_W-1:0] tap_m1,
    output logic [PIX_W-1:0] tap_c,
    output logic [PIX_W-1:0] tap_p1,
    output logic [PIX_W-1:0] tap_p2
);
    localparam int TAPS = 5;
    localparam int CTR  = TAPS / 2;

    // index 0 holds the newest sample (n+2), index TAPS-1 the oldest (n-2)
    typedef struct packed {
        logic [TAPS-1:0]            vld;
        logic [TAPS-1:0][PIX_W-1:0] pix;
    } win_t;

    win_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.vld = {st_q.vld[TAPS-2:0], in_valid};
        for (int i = TAPS - 1; i > 0; i--) begin
            st_d.pix[i] = st_q.pix[i-1];
        end
        st_d.pix[0] = in_valid ? in_pix : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // a gap in the valid run marks a line edge; repeat the nearest line sample
    always_comb begin
        ctr_valid = st_q.vld[CTR];
        tap_c     = st_q.pix[CTR];
        tap_p1    = st_q.vld[CTR-1] ? st_q.pix[CTR-1] : st_q.pix[CTR];
        tap_p2    = (st_q.vld[CTR-1] && st_q.vld[CTR-2]) ? st_q.pix[CTR-2] : tap_p1;
        tap_m1    = st_q.vld[CTR+1] ? st_q.pix[CTR+1] : st_q.pix[CTR];
        tap_m2    = (st_q.vld[CTR+1] && st_q.vld[CTR+2]) ? st_q.pix[CTR+2] : tap_m1;
    end

endmodule

// File: rtl/luma_pk_detail.sv
module luma_pk_detail
    import luma_pk_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int DET_W = PIX_W + 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ctr_valid,
    input  logic [PIX_W-1:0]        tap_m2,
    input  logic [PIX_W-1:0]        tap_m1,
    input  logic [PIX_W-1:0]        tap_c,
    input  logic [PIX_W-1:0]        tap_p1,
    input  logic [PIX_W-1:0]        tap_p2,
    input  logic [1:0]              bp_wt,
    input  logic [1:0]              hp_wt,
    output logic                    det_valid,
    output logic [PIX_W-1:0]        det_ctr,
    output logic signed [DET_W-1:0] det_val
);
    localparam int S_W = PIX_W + 3;
    localparam int PAD = S_W - PIX_W;

    typedef struct packed {
        logic                    valid;
        logic [PIX_W-1:0]        ctr;
        logic signed [DET_W-1:0] det;
    } det_t;

    det_t st_d, st_q;

    // weight in fine units: 1/8 -> x4, 1/4 -> x8, 1/2 -> x16
    function automatic logic signed [DET_W-1:0] wscale(
        input logic [1:0]            code,
        input logic signed [S_W-1:0] s
    );
        logic signed [DET_W-1:0] se;
        se = DET_W'(s);
        case (code)
            WT_EIGHTH:  return se <<< 2;
            WT_QUARTER: return se <<< 3;
            WT_HALF:    return se <<< 4;
            default:    return '0;
        endcase
    endfunction

    logic signed [S_W-1:0] c_s, m1_s, m2_s, p1_s, p2_s;
    logic signed [S_W-1:0] bp_s, hp_s;

    always_comb begin
        c_s  = $signed({{PAD{1'b0}}, tap_c});
        m1_s = $signed({{PAD{1'b0}}, tap_m1});
        m2_s = $signed({{PAD{1'b0}}, tap_m2});
        p1_s = $signed({{PAD{1'b0}}, tap_p1});
        p2_s = $signed({{PAD{1'b0}}, tap_p2});
        bp_s = (c_s <<< 1) - m2_s - p2_s;
        hp_s = (c_s <<< 1) - m1_s - p1_s;

        st_d       = st_q;
        st_d.valid = ctr_valid;
        st_d.ctr   = ctr_valid ? tap_c : '0;
        st_d.det   = ctr_valid ? (wscale(bp_wt, bp_s) + wscale(hp_wt, hp_s)) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign det_valid = st_q.valid;
    assign det_ctr   = st_q.ctr;
    assign det_val   = st_q.det;

    // R2: zero weights on both bands leave no detail behind
    assert_zero_weight_no_detail_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_valid && bp_wt == WT_ZERO && hp_wt == WT_ZERO) |=> (det_val == '0));

endmodule

// File: rtl/luma_pk_coresum.sv
module luma_pk_coresum
    import luma_pk_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int DET_W = PIX_W + 7,
    parameter int SUM_W = PIX_W + 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    det_valid,
    input  logic [PIX_W-1:0]        det_ctr,
    input  logic signed [DET_W-1:0] det_val,
    input  logic [1:0]              core_sel,
    output logic                    sum_valid,
    output logic signed [SUM_W-1:0] sum_val
);
    localparam int CPAD = SUM_W - PIX_W;

    typedef struct packed {
        logic                    valid;
        logic signed [DET_W-1:0] cored;
        logic signed [SUM_W-1:0] sum;
    } cs_t;

    cs_t st_d, st_q;

    logic signed [DET_W-1:0] mag;
    logic signed [DET_W-1:0] thr;
    logic signed [DET_W-1:0] kept;
    logic signed [SUM_W-1:0] base;

    always_comb begin
        mag  = (det_val < 0) ? -det_val : det_val;
        thr  = $signed(DET_W'(core_limit(core_sel)));
        kept = (mag <= thr) ? '0 : det_val;
        base = $signed({{CPAD{1'b0}}, det_ctr}) <<< FINE_SH;

        st_d       = st_q;
        st_d.valid = det_valid;
        st_d.cored = det_valid ? kept : '0;
        st_d.sum   = det_valid ? (base + SUM_W'(kept)) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum_valid = st_q.valid;
    assign sum_val   = st_q.sum;

    // R5: the detail reaching the adder is either removed or taken whole
    assert_core_whole_or_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        det_valid |=> (st_q.cored == '0 || st_q.cored == $past(det_val)));

    // R4: with coring off the detail is never altered
    assert_core_off_transparent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (det_valid && core_sel == CORE_OFF) |=> (st_q.cored == $past(det_val)));

endmodule

// File: rtl/luma_pk_limit.sv
module luma_pk_limit
    import luma_pk_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int SUM_W = PIX_W + 8,
    parameter int OUT_W = PIX_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sum_valid,
    input  logic signed [SUM_W-1:0] sum_val,
    output logic                    out_valid,
    output logic [OUT_W-1:0]        out_pix
);
    localparam logic signed [SUM_W-1:0] TOP = SUM_W'((1 << OUT_W) - 1);

    typedef struct packed {
        logic             valid;
        logic [OUT_W-1:0] pix;
    } lim_t;

    lim_t st_d, st_q;

    logic signed [SUM_W-1:0] scaled;
    logic [OUT_W-1:0]        clipped;

    always_comb begin
        scaled = sum_val >>> OUT_SH;
        if (scaled < 0) begin
            clipped = '0;
        end else if (scaled > TOP) begin
            clipped = '1;
        end else begin
            clipped = scaled[OUT_W-1:0];
        end

        st_d       = st_q;
        st_d.valid = sum_valid;
        st_d.pix   = sum_valid ? clipped : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_pix   = st_q.pix;

    // R6: a negative sum lands on the floor
    assert_clip_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_valid && sum_val < 0) |=> (out_pix == '0));

    // R6: a sum beyond full scale lands on the ceiling
    assert_clip_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_valid && sum_val >= ((TOP + 1) <<< OUT_SH)) |=> (out_pix == '1));

endmodule

// File: rtl/luma_peaker.sv
module luma_peaker
    import luma_pk_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_luma,
    input  logic [1:0]       cfg_bp_wt,
    input  logic [1:0]       cfg_hp_wt,
    input  logic [1:0]       cfg_core,
    output logic             out_valid,
    output logic [PIX_W:0]   out_luma
);
    localparam int DET_W = PIX_W + 7;
    localparam int SUM_W = PIX_W + 8;
    localparam int OUT_W = PIX_W + 1;

    logic                    ctr_valid;
    logic [PIX_W-1:0]        tap_m2, tap_m1, tap_c, tap_p1, tap_p2;
    logic                    det_valid;
    logic [PIX_W-1:0]        det_ctr;
    logic signed [DET_W-1:0] det_val;
    logic                    sum_valid;
    logic signed [SUM_W-1:0] sum_val;

    luma_pk_window #(.PIX_W(PIX_W)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_pix    (in_luma),
        .ctr_valid (ctr_valid),
        .tap_m2    (tap_m2),
        .tap_m1    (tap_m1),
        .tap_c     (tap_c),
        .tap_p1    (tap_p1),
        .tap_p2    (tap_p2)
    );

    luma_pk_detail #(.PIX_W(PIX_W), .DET_W(DET_W)) u_detail (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctr_valid (ctr_valid),
        .tap_m2    (tap_m2),
        .tap_m1    (tap_m1),
        .tap_c     (tap_c),
        .tap_p1    (tap_p1),
        .tap_p2    (tap_p2),
        .bp_wt     (cfg_bp_wt),
        .hp_wt     (cfg_hp_wt),
        .det_valid (det_valid),
        .det_ctr   (det_ctr),
        .det_val   (det_val)
    );

    luma_pk_coresum #(.PIX_W(PIX_W), .DET_W(DET_W), .SUM_W(SUM_W)) u_coresum (
        .clk       (clk),
        .rst_n     (rst_n),
        .det_valid (det_valid),
        .det_ctr   (det_ctr),
        .det_val   (det_val),
        .core_sel  (cfg_core),
        .sum_valid (sum_valid),
        .sum_val   (sum_val)
    );

    luma_pk_limit #(.PIX_W(PIX_W), .SUM_W(SUM_W), .OUT_W(OUT_W)) u_limit (
        .clk       (clk),
        .rst_n     (rst_n),
        .sum_valid (sum_valid),
        .sum_val   (sum_val),
        .out_valid (out_valid),
        .out_pix   (out_luma)
    );

    // cycles since reset, so the pipeline checks never reach back past reset
    logic [2:0] since_rst_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst_q <= '0;
        end else if (since_rst_q != 3'd7) begin
            since_rst_q <= since_rst_q + 3'd1;
        end
    end

    // R7: one output per input, a fixed distance behind it
    assert_fixed_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q >= 3'(LATENCY + 1)) |-> (out_valid == $past(in_valid, LATENCY + 1)));

    // R1: with both weights zero the sample passes through scaled by two
    assert_passthrough_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q >= 3'(LATENCY + 1) && out_valid &&
         $past(cfg_bp_wt == WT_ZERO && cfg_hp_wt == WT_ZERO, 3))
        |-> (out_luma == {$past(in_luma, LATENCY + 1), 1'b0}));

endmodule

// File: tb/luma_peaker_tb.sv
module luma_peaker_tb;

    localparam int CLK_NS = 10;
    localparam int LAT    = 5;
    localparam int NVEC   = 10;

    typedef struct packed {
        logic [1:0] wa;
        logic [1:0] wb;
        logic [1:0] cor;
        logic [7:0] s0;
        logic [7:0] s1;
        logic [7:0] s2;
        logic [7:0] s3;
        logic [7:0] s4;
        logic [8:0] exp_ctr;
    } vec_t;

    // five-sample lines; the expected value is the output of the centre sample
    localparam vec_t VEC [0:NVEC-1] = '{
        '{2'd3, 2'd3, 2'd0, 8'd100, 8'd100, 8'd100, 8'd100, 8'd100, 9'd200}, // R3 flat
        '{2'd1, 2'd0, 2'd0, 8'd10,  8'd20,  8'd200, 8'd20,  8'd10,  9'd495}, // R2 band-pass only
        '{2'd0, 2'd3, 2'd0, 8'd10,  8'd20,  8'd200, 8'd20,  8'd10,  9'd511}, // R6 ceiling
        '{2'd3, 2'd3, 2'd0, 8'd250, 8'd250, 8'd10,  8'd250, 8'd250, 9'd0},   // R6 floor
        '{2'd1, 2'd0, 2'd0, 8'd100, 8'd100, 8'd100, 8'd100, 8'd101, 9'd199}, // R3 truncation
        '{2'd1, 2'd0, 2'd1, 8'd100, 8'd100, 8'd100, 8'd100, 8'd101, 9'd200}, // R4 equality cored
        '{2'd1, 2'd0, 2'd3, 8'd100, 8'd100, 8'd100, 8'd100, 8'd102, 9'd199}, // R5 above threshold
        '{2'd2, 2'd1, 2'd0, 8'd50,  8'd60,  8'd80,  8'd70,  8'd40,  9'd202}, // R2 mixed weights
        '{2'd0, 2'd2, 2'd0, 8'd0,   8'd0,   8'd255, 8'd0,   8'd0,   9'd511}, // R2 high-pass only
        '{2'd0, 2'd0, 2'd0, 8'd37,  8'd200, 8'd123, 8'd9,   8'd255, 9'd246}  // R1 pass-through
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_luma = '0;
    logic [1:0] cfg_bp_wt = '0;
    logic [1:0] cfg_hp_wt = '0;
    logic [1:0] cfg_core = '0;
    logic       out_valid;
    logic [8:0] out_luma;

    int n_checks = 0;
    int n_fail   = 0;
    int ln  [0:31];
    int cap [0:63];
    int ncap = 0;
    bit done = 1'b0;

    always #(CLK_NS / 2) clk = ~clk;

    luma_peaker u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_luma   (in_luma),
        .cfg_bp_wt (cfg_bp_wt),
        .cfg_hp_wt (cfg_hp_wt),
        .cfg_core  (cfg_core),
        .out_valid (out_valid),
        .out_luma  (out_luma)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid && ncap < 64) begin
            cap[ncap] = int'(out_luma);
            ncap = ncap + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // independent model of the requirements; lo..hi bound the sample's line
    function automatic int model(input int idx, input int lo, input int hi,
                                 input int wa, input int wb, input int cor);
        int c, m1, m2, p1, p2, d, t, thr, mag, r;
        int wm [0:3] = '{0, 4, 8, 16};   // weights in 1/32 input-LSB units (R2)
        int tm [0:3] = '{0, 4, 6, 7};    // coring thresholds, same units (R4)
        c  = ln[idx];
        m1 = ln[(idx - 1 < lo) ? lo : idx - 1];
        m2 = ln[(idx - 2 < lo) ? lo : idx - 2];
        p1 = ln[(idx + 1 > hi) ? hi : idx + 1];
        p2 = ln[(idx + 2 > hi) ? hi : idx + 2];
        d  = wm[wa] * (2 * c - m2 - p2) + wm[wb] * (2 * c - m1 - p1);
        thr = tm[cor];
        mag = (d < 0) ? -d : d;
        if (mag <= thr) d = 0;
        t = 32 * c + d;
        r = t >>> 4;
        if (r < 0) r = 0;
        if (r > 511) r = 511;
        return r;
    endfunction

    // drive line A (ln[0..la-1]) and optionally line B after one idle cycle
    task automatic run_lines(input int la, input int lb, input int wa, input int wb, input int cor);
        @(negedge clk);
        cfg_bp_wt = 2'(wa);
        cfg_hp_wt = 2'(wb);
        cfg_core  = 2'(cor);
        repeat (2) @(negedge clk);
        ncap = 0;
        for (int i = 0; i < la; i++) begin
            in_valid = 1'b1;
            in_luma  = 8'(ln[i]);
            @(negedge clk);
        end
        if (lb > 0) begin
            in_valid = 1'b0;
            @(negedge clk);
            for (int i = 0; i < lb; i++) begin
                in_valid = 1'b1;
                in_luma  = 8'(ln[la + i]);
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        in_luma  = '0;
        repeat (LAT + 3) @(negedge clk);
        chk("R7 output count", ncap, la + lb);
        for (int i = 0; i < la + lb && i < ncap; i++) begin
            if (i < la) chk("R9 line A sample", cap[i], model(i, 0, la - 1, wa, wb, cor));
            else        chk("R9 line B sample", cap[i], model(i, la, la + lb - 1, wa, wb, cor));
        end
        chk("R8 idle valid", int'(out_valid), 0);
        chk("R8 idle data", int'(out_luma), 0);
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R10: outputs held at zero during reset
        repeat (3) @(negedge clk);
        chk("R10 reset valid", int'(out_valid), 0);
        chk("R10 reset data", int'(out_luma), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // vector table
        for (int v = 0; v < NVEC; v++) begin
            ln[0] = int'(VEC[v].s0);
            ln[1] = int'(VEC[v].s1);
            ln[2] = int'(VEC[v].s2);
            ln[3] = int'(VEC[v].s3);
            ln[4] = int'(VEC[v].s4);
            run_lines(5, 0, int'(VEC[v].wa), int'(VEC[v].wb), int'(VEC[v].cor));
            chk("R3 table centre", cap[2], int'(VEC[v].exp_ctr));
        end

        // R7: latency of a lone sample, counted in edges
        @(negedge clk);
        cfg_bp_wt = 2'd0; cfg_hp_wt = 2'd0; cfg_core = 2'd0;
        in_valid = 1'b1;
        in_luma  = 8'd77;
        @(negedge clk);
        in_valid = 1'b0;
        in_luma  = '0;
        repeat (LAT - 1) @(negedge clk);
        chk("R7 not yet valid", int'(out_valid), 0);
        @(negedge clk);
        chk("R7 valid on time", int'(out_valid), 1);
        chk("R1 lone sample", int'(out_luma), 154);
        @(negedge clk);
        chk("R7 single pulse", int'(out_valid), 0);

        // R9: one-sample line at full weights gives 2x
        ln[0] = 77;
        run_lines(1, 0, 3, 3, 0);
        chk("R9 single sample", cap[0], 154);

        // R9: two-sample line, edge repeat on both sides
        ln[0] = 10; ln[1] = 250;
        run_lines(2, 0, 3, 3, 0);

        // R9: two lines one idle cycle apart, edges not shared
        ln[0] = 200; ln[1] = 200; ln[2] = 200;
        ln[3] = 0;   ln[4] = 0;   ln[5] = 0; ln[6] = 0;
        run_lines(3, 4, 3, 3, 0);
        chk("R9 line A tail", cap[2], 400);
        chk("R9 line B head", cap[3], 0);

        // R1: pass-through with coring on, longer ramp
        for (int i = 0; i < 12; i++) ln[i] = (i * 37) % 256;
        run_lines(12, 0, 0, 0, 3);
        for (int i = 0; i < 12; i++) chk("R1 ramp pass-through", cap[i], 2 * ((i * 37) % 256));

        // R4: each nonzero coring code on the same small detail
        for (int c = 1; c < 4; c++) begin
            ln[0] = 100; ln[1] = 100; ln[2] = 100; ln[3] = 100; ln[4] = 101;
            run_lines(5, 0, 1, 0, c);
            chk("R4 coring code", cap[2], 200);
        end

        // R10: reset with samples in flight drops them
        @(negedge clk);
        cfg_bp_wt = 2'd1; cfg_hp_wt = 2'd1; cfg_core = 2'd0;
        ncap = 0;
        for (int i = 0; i < 3; i++) begin
            in_valid = 1'b1;
            in_luma  = 8'(50 + i);
            @(negedge clk);
        end
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        chk("R10 mid reset valid", int'(out_valid), 0);
        chk("R10 mid reset data", int'(out_luma), 0);
        rst_n = 1'b1;
        repeat (LAT + 3) @(negedge clk);
        chk("R10 no stray output", ncap, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule